// File: doc/BRIEF.md
# Result-Bus Slot Scheduler for Mixed-Latency Units

Several execution units with different fixed latencies write their results onto one shared result bus. This block books bus time for them. When an instruction is offered for issue with a latency K, the block checks whether the result bus is already booked for the cycle in which that result would appear. If the bus is free for that cycle, the issue is accepted and a token holding the instruction's tag and unit number is placed in a chain of slots. The token's position in the chain is the number of cycles left until its data is due. If the bus is already booked, the issue is refused, so bus contention is settled at issue time and never later.

The token moves one slot closer to the end of the chain on every clock. While it moves, the block announces the tag on a tag bus one cycle before the data. Waiting instructions can then wake up in time to catch the data through a bypass. In the data cycle the block drives the tag and unit number on the data side, together with a one-hot grant that tells the owning unit to drive the bus. A flush input cancels every booking at once.

Top module: `lrs_result_sched`

## Requirements
- R1: During reset and after it, `tag_valid`, `data_valid` and `data_grant` are low. No slot is booked, so the first issue with a legal latency is accepted.
- R2: An issue with latency K of 2 or more, accepted in cycle n, drives `tag_valid` high with `tag_bus` equal to its tag in cycle n+K-1 and in no other cycle.
- R3: The same issue drives `data_valid` high in cycle n+K, with `data_tag` equal to its tag and `data_unit` equal to its unit number. In that cycle `data_grant` has exactly one bit set, at position `data_unit` (bit u for unit u); in every other cycle it is zero.
- R4: An issue with latency 1 puts its tag on `tag_bus` with `tag_valid` high in the issue cycle itself, combinationally from the issue inputs. Its data follows in the next cycle.
- R5: An issue with latency 0, or with a latency above `MAX_LAT`, is refused (`iss_accept` low) and produces no tag or data cycle.
- R6: An issue whose data cycle n+K is already booked by an earlier accepted issue is refused. The earlier booking still delivers its own tag and data unchanged.
- R7: While `flush` is high, `iss_accept`, `tag_valid` and `data_valid` are low. No booking made before or during that cycle ever produces a tag or data cycle.
- R8: Issues in consecutive cycles with the same latency, or with different latencies whose data cycles do not meet, are all accepted. Each is delivered in its own cycle.
- R9: Whenever `tag_valid` is high, the next cycle carries `data_valid` with the same tag, unless `flush` is high in that next cycle. `data_valid` is never high unless `tag_valid` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Cancels every booking and blocks issue this cycle |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_lat | input | LAT_W | Latency K of the offered instruction |
| iss_tag | input | TAG_W | Tag of the offered instruction |
| iss_unit | input | UNIT_W | Unit that will produce the result |
| iss_accept | output | 1 | Issue accepted (combinational) |
| tag_valid | output | 1 | Early tag broadcast valid |
| tag_bus | output | TAG_W | Tag being broadcast |
| data_valid | output | 1 | Result bus is granted this cycle |
| data_tag | output | TAG_W | Tag of the result on the bus |
| data_unit | output | UNIT_W | Unit granted the bus |
| data_grant | output | N_UNITS | One-hot bus grant per unit |

## Verification
`iss_accept` and the tag broadcast for latency 1 are combinational, so they are due in the issue cycle itself. A booking with latency K produces its tag K-1 clock edges after the issue edge and its data K edges after it. The bench keeps a reference schedule indexed by absolute cycle number. It applies inputs on the falling edge and compares every output a moment later in each cycle, so each result is checked in exactly the cycle it is due and found absent in all the others. Flushes erase the future part of the reference schedule, which confirms that cancelled bookings never surface.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   // Bits needed to encode latencies 0..max (0 is the illegal code).
   function automatic int lat_bits(input int max_lat);
      return $clog2(max_lat + 1);
   endfunction

   // Bits needed to number the units (at least one).
   function automatic int unit_bits(input int n_units);
      return (n_units > 1) ? $clog2(n_units) : 1;
   endfunction
endpackage

// File: rtl/lrs_issue_check.sv
module lrs_issue_check #(
   parameter int MAX_LAT = 8,
   parameter int LAT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iss_valid,
   input  logic [LAT_W-1:0]   iss_lat,
   input  logic               flush,
   input  logic [MAX_LAT-1:0] occ,
   output logic               accept,
   output logic [LAT_W-1:0]   ins_idx,
   output logic               fast
);
   logic lat_ok;
   logic slot_busy;

   // A slot i holds a token whose data is due i cycles from now.
   // After this edge every slot shifts down by one, so a new token of
   // latency K lands where slot K sits today.
   always_comb begin
      lat_ok    = (iss_lat != '0) && (iss_lat <= LAT_W'(MAX_LAT));
      slot_busy = 1'b0;
      for (int i = 1; i < MAX_LAT; i++) begin
         if ((iss_lat == LAT_W'(i)) && occ[i]) slot_busy = 1'b1;
      end
   end

   assign accept  = iss_valid && !flush && lat_ok && !slot_busy;
   assign ins_idx = iss_lat - LAT_W'(1);
   assign fast    = accept && (iss_lat == LAT_W'(1));

   // R5
   legal_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (iss_lat != '0) && (iss_lat <= LAT_W'(MAX_LAT)));
   // R7
   flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !accept);
endmodule

// File: rtl/lrs_slot_chain.sv
module lrs_slot_chain #(
   parameter int MAX_LAT = 8,
   parameter int TAG_W   = 6,
   parameter int UNIT_W  = 2,
   parameter int LAT_W   = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clear,
   input  logic                           ins_en,
   input  logic [LAT_W-1:0]               ins_idx,
   input  logic [TAG_W-1:0]               ins_tag,
   input  logic [UNIT_W-1:0]              ins_unit,
   output logic [MAX_LAT-1:0]             occ,
   output logic [MAX_LAT-1:0][TAG_W-1:0]  s_tag,
   output logic [MAX_LAT-1:0][UNIT_W-1:0] s_unit
);
   logic [MAX_LAT-1:0]             nxt_v;
   logic [MAX_LAT-1:0][TAG_W-1:0]  nxt_t;
   logic [MAX_LAT-1:0][UNIT_W-1:0] nxt_u;

   for (genvar i = 0; i < MAX_LAT; i++) begin : g_slot
      logic hit;
      assign hit = ins_en && (ins_idx == LAT_W'(i));
      if (i == MAX_LAT - 1) begin : g_last
         // Nothing shifts into the farthest slot.
         assign nxt_v[i] = hit;
         assign nxt_t[i] = ins_tag;
         assign nxt_u[i] = ins_unit;
      end else begin : g_inner
         assign nxt_v[i] = hit | occ[i+1];
         assign nxt_t[i] = hit ? ins_tag  : s_tag[i+1];
         assign nxt_u[i] = hit ? ins_unit : s_unit[i+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ    <= '0;
         s_tag  <= '0;
         s_unit <= '0;
      end else if (clear) begin
         occ    <= '0;
         s_tag  <= '0;
         s_unit <= '0;
      end else begin
         occ    <= nxt_v;
         s_tag  <= nxt_t;
         s_unit <= nxt_u;
      end
   end

   // R6
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> (ins_idx == LAT_W'(MAX_LAT - 1)) || !occ[ins_idx + LAT_W'(1)]);
   // R2
   booking_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !clear) |=> occ[$past(ins_idx)] && (s_tag[$past(ins_idx)] == $past(ins_tag)));
   // R7
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (occ == '0));
endmodule

// File: rtl/lrs_bus_drive.sv
module lrs_bus_drive #(
   parameter int TAG_W   = 6,
   parameter int UNIT_W  = 2,
   parameter int N_UNITS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               near_v,
   input  logic [TAG_W-1:0]   near_tag,
   input  logic               head_v,
   input  logic [TAG_W-1:0]   head_tag,
   input  logic [UNIT_W-1:0]  head_unit,
   input  logic               fast,
   input  logic [TAG_W-1:0]   fast_tag,
   output logic               tag_valid,
   output logic [TAG_W-1:0]   tag_bus,
   output logic               data_valid,
   output logic [TAG_W-1:0]   data_tag,
   output logic [UNIT_W-1:0]  data_unit,
   output logic [N_UNITS-1:0] data_grant
);
   // Slot 1 and a latency-1 issue never coexist: the issue check
   // refuses the latter while slot 1 is booked.
   always_comb begin
      tag_valid = 1'b0;
      tag_bus   = '0;
      if (!flush) begin
         if (near_v) begin
            tag_valid = 1'b1;
            tag_bus   = near_tag;
         end else if (fast) begin
            tag_valid = 1'b1;
            tag_bus   = fast_tag;
         end
      end
   end

   assign data_valid = head_v && !flush;
   assign data_tag   = head_tag;
   assign data_unit  = head_unit;

   for (genvar u = 0; u < N_UNITS; u++) begin : g_grant
      assign data_grant[u] = data_valid && (head_unit == UNIT_W'(u));
   end

   // R3
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_grant));
   // R3
   grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid == (data_grant != '0));
   // R6
   fast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(near_v && fast));
endmodule

// File: rtl/lrs_result_sched.sv
module lrs_result_sched
   import lrs_pkg::*;
#(
   parameter int MAX_LAT = 8,
   parameter int TAG_W   = 6,
   parameter int N_UNITS = 4,
   localparam int LAT_W  = lat_bits(MAX_LAT),
   localparam int UNIT_W = unit_bits(N_UNITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               iss_valid,
   input  logic [LAT_W-1:0]   iss_lat,
   input  logic [TAG_W-1:0]   iss_tag,
   input  logic [UNIT_W-1:0]  iss_unit,
   output logic               iss_accept,
   output logic               tag_valid,
   output logic [TAG_W-1:0]   tag_bus,
   output logic               data_valid,
   output logic [TAG_W-1:0]   data_tag,
   output logic [UNIT_W-1:0]  data_unit,
   output logic [N_UNITS-1:0] data_grant
);
   if (MAX_LAT < 2) begin : g_bad_lat
      $error("MAX_LAT must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be at least 1");
   end
   if (N_UNITS < 2) begin : g_bad_units
      $error("N_UNITS must be at least 2");
   end

   logic [MAX_LAT-1:0]             occ;
   logic [MAX_LAT-1:0][TAG_W-1:0]  s_tag;
   logic [MAX_LAT-1:0][UNIT_W-1:0] s_unit;
   logic [LAT_W-1:0]               ins_idx;
   logic                           fast;

   lrs_issue_check #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_check (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_lat(iss_lat), .flush(flush), .occ(occ),
      .accept(iss_accept), .ins_idx(ins_idx), .fast(fast)
   );

   lrs_slot_chain #(.MAX_LAT(MAX_LAT), .TAG_W(TAG_W), .UNIT_W(UNIT_W), .LAT_W(LAT_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .ins_en(iss_accept), .ins_idx(ins_idx), .ins_tag(iss_tag), .ins_unit(iss_unit),
      .occ(occ), .s_tag(s_tag), .s_unit(s_unit)
   );

   lrs_bus_drive #(.TAG_W(TAG_W), .UNIT_W(UNIT_W), .N_UNITS(N_UNITS)) u_drive (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .near_v(occ[1]), .near_tag(s_tag[1]),
      .head_v(occ[0]), .head_tag(s_tag[0]), .head_unit(s_unit[0]),
      .fast(fast), .fast_tag(iss_tag),
      .tag_valid(tag_valid), .tag_bus(tag_bus),
      .data_valid(data_valid), .data_tag(data_tag), .data_unit(data_unit),
      .data_grant(data_grant)
   );

   // R9
   tag_leads_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |=> flush || (data_valid && (data_tag == $past(tag_bus))));
   // R9
   data_after_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> $past(tag_valid));
   // R7
   flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !tag_valid && !data_valid);
   // R7
   flush_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !data_valid);
   // R4
   fast_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_accept && (iss_lat == LAT_W'(1))) |-> tag_valid && (tag_bus == iss_tag));
endmodule

// File: tb/lrs_result_sched_bench.sv
module lrs_result_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_LAT = 8;
   localparam int TAG_W   = 6;
   localparam int N_UNITS = 4;
   localparam int LAT_W   = $clog2(MAX_LAT + 1);
   localparam int UNIT_W  = $clog2(N_UNITS);
   localparam int DEPTH   = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               flush = 1'b0;
   logic               iss_valid = 1'b0;
   logic [LAT_W-1:0]   iss_lat = '0;
   logic [TAG_W-1:0]   iss_tag = '0;
   logic [UNIT_W-1:0]  iss_unit = '0;
   logic               iss_accept;
   logic               tag_valid;
   logic [TAG_W-1:0]   tag_bus;
   logic               data_valid;
   logic [TAG_W-1:0]   data_tag;
   logic [UNIT_W-1:0]  data_unit;
   logic [N_UNITS-1:0] data_grant;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   // Reference schedule indexed by cycle number modulo DEPTH.
   bit e_tv [DEPTH];
   int e_tt [DEPTH];
   bit e_dv [DEPTH];
   int e_dt [DEPTH];
   int e_du [DEPTH];

   lrs_result_sched #(.MAX_LAT(MAX_LAT), .TAG_W(TAG_W), .N_UNITS(N_UNITS)) u_lrs_result_sched (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .iss_valid(iss_valid), .iss_lat(iss_lat), .iss_tag(iss_tag), .iss_unit(iss_unit),
      .iss_accept(iss_accept), .tag_valid(tag_valid), .tag_bus(tag_bus),
      .data_valid(data_valid), .data_tag(data_tag), .data_unit(data_unit),
      .data_grant(data_grant)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   // One clock cycle: drive at the falling edge, check a moment later.
   task automatic step(input bit v, input int lat, input int tg, input int un,
                       input bit fl, input string req);
      bit exp_acc;
      int cur;
      int exp_grant;
      @(negedge clk);
      iss_valid = v;
      iss_lat   = LAT_W'(lat);
      iss_tag   = TAG_W'(tg);
      iss_unit  = UNIT_W'(un);
      flush     = fl;
      #1;
      cur = cyc % DEPTH;
      exp_acc = v && !fl && (lat >= 1) && (lat <= MAX_LAT) && !e_dv[(cyc + lat) % DEPTH];
      chk(iss_accept == exp_acc, req, "accept", int'(iss_accept), int'(exp_acc));
      if (exp_acc) begin
         e_tv[(cyc + lat - 1) % DEPTH] = 1'b1;
         e_tt[(cyc + lat - 1) % DEPTH] = tg;
         e_dv[(cyc + lat) % DEPTH] = 1'b1;
         e_dt[(cyc + lat) % DEPTH] = tg;
         e_du[(cyc + lat) % DEPTH] = un;
      end
      if (fl) begin
         for (int j = 0; j < DEPTH; j++) begin
            e_tv[j] = 1'b0;
            e_dv[j] = 1'b0;
         end
      end
      // R9: tag/data pairing follows from the schedule entries.
      chk(tag_valid == e_tv[cur], req, "tag_valid", int'(tag_valid), int'(e_tv[cur]));
      if (e_tv[cur])
         chk(int'(tag_bus) == e_tt[cur], req, "tag_bus", int'(tag_bus), e_tt[cur]);
      chk(data_valid == e_dv[cur], req, "data_valid", int'(data_valid), int'(e_dv[cur]));
      exp_grant = e_dv[cur] ? (1 << e_du[cur]) : 0;
      chk(int'(data_grant) == exp_grant, req, "data_grant", int'(data_grant), exp_grant);
      if (e_dv[cur]) begin
         chk(int'(data_tag) == e_dt[cur], req, "data_tag", int'(data_tag), e_dt[cur]);
         chk(int'(data_unit) == e_du[cur], req, "data_unit", int'(data_unit), e_du[cur]);
      end
      e_tv[cur] = 1'b0;
      e_dv[cur] = 1'b0;
      @(posedge clk);
      cyc++;
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, req);
   endtask

   // R1: quiet outputs in and after reset, first legal issue accepted
   task automatic t_reset();
      #1;
      chk(!tag_valid && !data_valid && data_grant == '0, "R1", "outputs in reset",
          int'(tag_valid) + int'(data_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      cyc = 0;
      idle(2, "R1");
      step(1'b1, MAX_LAT, 3, 1, 1'b0, "R1");
      idle(MAX_LAT + 1, "R1");
   endtask

   // R2 R3: single issues of middle and maximum latency, each unit
   task automatic t_single();
      step(1'b1, 3, 5, 2, 1'b0, "R2");
      idle(4, "R3");
      step(1'b1, 2, 9, 0, 1'b0, "R2");
      idle(3, "R3");
      step(1'b1, MAX_LAT, 33, 3, 1'b0, "R2");
      idle(MAX_LAT + 1, "R3");
   endtask

   // R4: latency one, tag in the issue cycle
   task automatic t_fast();
      step(1'b1, 1, 17, 1, 1'b0, "R4");
      step(1'b1, 1, 18, 2, 1'b0, "R4");
      idle(2, "R4");
   endtask

   // R5: illegal latencies 0 and MAX_LAT+1
   task automatic t_bad_lat();
      step(1'b1, 0, 40, 1, 1'b0, "R5");
      step(1'b1, MAX_LAT + 1, 41, 2, 1'b0, "R5");
      idle(MAX_LAT + 2, "R5");
   endtask

   // R6: second issue aims at a booked cycle
   task automatic t_collide();
      step(1'b1, 4, 11, 1, 1'b0, "R6");
      step(1'b1, 3, 12, 2, 1'b0, "R6");
      step(1'b1, 2, 13, 3, 1'b0, "R6");
      step(1'b1, 1, 14, 0, 1'b0, "R6");
      idle(5, "R6");
   endtask

   // R8: back-to-back and interleaved latencies
   task automatic t_stream();
      for (int i = 0; i < 6; i++) step(1'b1, 2, 20 + i, i % N_UNITS, 1'b0, "R8");
      idle(3, "R8");
      step(1'b1, 6, 50, 0, 1'b0, "R8");
      step(1'b1, 2, 51, 1, 1'b0, "R8");
      step(1'b1, 5, 52, 2, 1'b0, "R8");
      step(1'b1, 1, 53, 3, 1'b0, "R8");
      idle(MAX_LAT + 1, "R8");
   endtask

   // R7: flush cancels bookings and blocks a same-cycle issue
   task automatic t_flush();
      step(1'b1, 6, 60, 1, 1'b0, "R7");
      step(1'b1, 3, 61, 2, 1'b0, "R7");
      step(1'b1, 2, 62, 0, 1'b0, "R7");
      step(1'b1, 2, 63, 3, 1'b1, "R7");
      idle(MAX_LAT + 1, "R7");
      step(1'b1, 1, 7, 2, 1'b0, "R7");
      step(1'b1, 2, 8, 1, 1'b1, "R7");
      idle(3, "R7");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int j = 0; j < DEPTH; j++) begin
         e_tv[j] = 1'b0;
         e_dv[j] = 1'b0;
         e_tt[j] = 0;
         e_dt[j] = 0;
         e_du[j] = 0;
      end
      t_reset();
      t_single();
      t_fast();
      t_bad_lat();
      t_collide();
      t_stream();
      t_flush();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule